// File: doc/BRIEF.md
# Reciprocal square root estimate unit

This block produces a coarse reciprocal square root for one 32-bit operand per cycle. A mode input picks how the operand is read: as a single-precision float, or as an unsigned fixed-point fraction with the binary point above bit 31. The result is a 32-bit word in the same format, together with an invalid-operation flag and a divide-by-zero flag. The estimate is meant to seed later refinement steps, which are not part of this block.

The operand's significand is moved into the interval [0.25, 1). The parity of the float exponent decides which half of that interval is used, so that halving the exponent gives an exact result. Each half of the interval is split into 128 equal steps, with a step twice as fine in the lower half. Each step maps to an 8-bit fraction that is rounded to the nearest 1/256. These fractions are computed once, when the design is elaborated, and held in a constant table. Special operands (NaN, zero, denormal, negative, infinity, and fixed-point values below 0.25) bypass the table. The result and flags are registered, so they appear one cycle after the operand is presented.

Top module: `rsqrt_est`

## Requirements
- R1: Result and flags are registered. After an operand is presented with `in_valid` high on a rising edge, `out_valid` is 1 after that edge and `out_result`/flags hold the answer. `out_valid` is 0 after any edge where `in_valid` was low. During reset all outputs are 0.
- R2: Float mode (`in_mode`=0), positive operand with biased exponent E in 1..254. Let t be mantissa bits 22:16 and q = 128 + t. If E is even, r = 1/sqrt((q+0.5)/256). If E is odd, r = 1/sqrt((q+0.5)/512). With s = floor(256*r + 0.5), the result has bit 31 = 0, bits 30:23 = floor((380-E)/2), bits 22:15 = s-256 and bits 14:0 = 0. No flag is raised. Mantissa bits 15:0 have no effect.
- R3: Float mode, NaN operand (E=255, mantissa nonzero). The result is 0x7FC00000 whatever the sign. Invalid is raised only when mantissa bit 22 is 0 (a signalling NaN). Invalid and divide-by-zero are never raised together.
- R4: Float mode, E=0 (zero or denormal). The result is the operand's sign in bit 31 with 0x7F800000 in bits 30:0, and divide-by-zero is raised.
- R5: Float mode, any other operand with bit 31 set (a negative normal or negative infinity). The result is 0x7FC00000 and invalid is raised.
- R6: Float mode, positive infinity (0x7F800000). The result is 0x00000000 with no flags.
- R7: Unsigned mode (`in_mode`=1), operand bits 31:30 both 0. The result is 0xFFFFFFFF.
- R8: Unsigned mode, operand bit 31 = 1. Take q = 128 + bits 30:24 and use the upper-interval r from R2. The result is bit 31 = 1, bits 30:23 = s-256, bits 22:0 = 0. Operand bits 23:0 have no effect.
- R9: Unsigned mode, operand bits 31:30 = 01. Take q = 128 + bits 29:23 and use the lower-interval r from R2. The result is packed as in R8.
- R10: Unsigned mode never raises invalid or divide-by-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_mode | input | 1 | 0 = single-precision float, 1 = unsigned fixed-point fraction |
| in_operand | input | 32 | Operand word |
| out_valid | output | 1 | Result word and flags are valid |
| out_result | output | 32 | Estimate or special-case word |
| out_invalid | output | 1 | Invalid-operation flag |
| out_divzero | output | 1 | Divide-by-zero flag |

## Verification
The hardest part to reach is the exact rounding boundary of every table entry. A single wrong rounding hides among 256 plausible fractions, and most random operands reach only a few of them. The stimulus therefore walks all 128 step indices in each interval, in both modes, and fills the mantissa bits below the index with changing junk so that their lack of effect is shown too. For each case the bench computes the expected fraction with a real-valued square root. Exponents are spread across the whole range so that both parities and both ends of the exponent halving are covered, and directed operands cover each special class, including signalling NaNs of either sign and negative denormals.

// File: rtl/rsqrt_est_pkg.sv
package rsqrt_est_pkg;

   // Kind of word the packer must build
   typedef enum logic [2:0] {
      RK_EST_FP   = 3'd0,
      RK_EST_UINT = 3'd1,
      RK_DEF_NAN  = 3'd2,
      RK_SGN_INF  = 3'd3,
      RK_ZERO     = 3'd4,
      RK_SATURATE = 3'd5
   } res_kind_e;

   localparam logic [31:0] DEF_NAN_WORD = 32'h7FC0_0000;
   localparam logic [30:0] INF_MAG      = 31'h7F80_0000;

   // Table entry for index {upper, step}: the largest s in [2^f, 2^(f+1))
   // with (s - 0.5) <= 2^f / sqrt(x), in exact integers:
   // (2s-1)^2 * (2q+1) <= 2^(2f+p+5-upper), q = 2^p + step.
   function automatic longint est_entry(input int p, input int f, input int idx);
      longint q, lim, lo, hi, mid;
      int     upper;
      int     k;
      upper = (idx >> p) & 1;
      q     = (longint'(1) << p) + longint'(idx & ((1 << p) - 1));
      k     = 2 * f + p + 5 - upper;
      lim   = (longint'(1) << k) / (2 * q + 1);
      lo    = longint'(1) << f;
      hi    = (longint'(1) << (f + 1)) - 1;
      while (lo < hi) begin
         mid = (lo + hi + 1) / 2;
         if ((2 * mid - 1) * (2 * mid - 1) <= lim) lo = mid;
         else hi = mid - 1;
      end
      return lo - (longint'(1) << f);
   endfunction

endpackage

// File: rtl/rsqrt_est_classify.sv
module rsqrt_est_classify
   import rsqrt_est_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic            uint_mode,
   input  logic [31:0]     operand,
   output res_kind_e       kind,
   output logic [IDX_W:0]  sel,
   output logic            sign,
   output logic [7:0]      half_exp,
   output logic            raise_inv,
   output logic            raise_dz
);
   localparam int MANT_W = 23;

   logic [7:0]        bexp;
   logic [MANT_W-1:0] mant;
   logic              exp_ones, exp_none, mant_none;

   assign sign      = operand[31];
   assign bexp      = operand[30:23];
   assign mant      = operand[MANT_W-1:0];
   assign exp_ones  = &bexp;
   assign exp_none  = ~|bexp;
   assign mant_none = ~|mant;
   assign half_exp  = 8'((9'd380 - {1'b0, bexp}) >> 1);

   always_comb begin
      kind      = RK_EST_FP;
      sel       = {~bexp[0], mant[MANT_W-1 -: IDX_W]};
      raise_inv = 1'b0;
      raise_dz  = 1'b0;
      if (uint_mode) begin
         if (operand[31]) begin
            kind = RK_EST_UINT;
            sel  = {1'b1, operand[30 -: IDX_W]};
         end else if (operand[30]) begin
            kind = RK_EST_UINT;
            sel  = {1'b0, operand[29 -: IDX_W]};
         end else begin
            kind = RK_SATURATE;
         end
      end else if (exp_ones && !mant_none) begin
         kind      = RK_DEF_NAN;
         raise_inv = ~mant[MANT_W-1];
      end else if (exp_none) begin
         kind     = RK_SGN_INF;
         raise_dz = 1'b1;
      end else if (sign) begin
         kind      = RK_DEF_NAN;
         raise_inv = 1'b1;
      end else if (exp_ones) begin
         kind = RK_ZERO;
      end
   end
endmodule

// File: rtl/rsqrt_est_table.sv
module rsqrt_est_table #(
   parameter int IDX_W  = 7,
   parameter int FRAC_W = 8
) (
   input  logic [IDX_W:0]    sel,
   output logic [FRAC_W-1:0] frac
);
   localparam int ENTRIES = 2 ** (IDX_W + 1);

   logic [FRAC_W-1:0] rom [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      localparam longint VAL = rsqrt_est_pkg::est_entry(IDX_W, FRAC_W, g);
      assign rom[g] = FRAC_W'(VAL);
   end

   assign frac = rom[sel];
endmodule

// File: rtl/rsqrt_est_pack.sv
module rsqrt_est_pack
   import rsqrt_est_pkg::*;
#(
   parameter int FRAC_W = 8
) (
   input  res_kind_e         kind,
   input  logic              sign,
   input  logic [7:0]        half_exp,
   input  logic [FRAC_W-1:0] frac,
   output logic [31:0]       word
);
   localparam int FP_PAD = 23 - FRAC_W;
   localparam int UI_PAD = 31 - FRAC_W;

   always_comb begin
      unique case (kind)
         RK_EST_FP:   word = {1'b0, half_exp, frac, {FP_PAD{1'b0}}};
         RK_EST_UINT: word = {1'b1, frac, {UI_PAD{1'b0}}};
         RK_DEF_NAN:  word = DEF_NAN_WORD;
         RK_SGN_INF:  word = {sign, INF_MAG};
         RK_SATURATE: word = '1;
         default:     word = '0;
      endcase
   end
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
   import rsqrt_est_pkg::*;
#(
   parameter int IDX_W   = 7,
   parameter int FRAC_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_mode,
   input  logic [31:0] in_operand,
   output logic        out_valid,
   output logic [31:0] out_result,
   output logic        out_invalid,
   output logic        out_divzero
);
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("rsqrt_est: IDX_W must lie in 1..10");
   end
   if (FRAC_W <= IDX_W || FRAC_W > 22) begin : g_bad_frac
      $error("rsqrt_est: FRAC_W must exceed IDX_W and be at most 22");
   end

   res_kind_e         kind;
   logic [IDX_W:0]    sel;
   logic              sign;
   logic [7:0]        half_exp;
   logic              raise_inv, raise_dz;
   logic [FRAC_W-1:0] frac;
   logic [31:0]       word;

   rsqrt_est_classify #(.IDX_W(IDX_W)) u_classify (
      .uint_mode (in_mode),
      .operand   (in_operand),
      .kind      (kind),
      .sel       (sel),
      .sign      (sign),
      .half_exp  (half_exp),
      .raise_inv (raise_inv),
      .raise_dz  (raise_dz)
   );

   rsqrt_est_table #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_table (
      .sel  (sel),
      .frac (frac)
   );

   rsqrt_est_pack #(.FRAC_W(FRAC_W)) u_pack (
      .kind     (kind),
      .sign     (sign),
      .half_exp (half_exp),
      .frac     (frac),
      .word     (word)
   );

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
            out_divzero <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_result  <= word;
               out_invalid <= raise_inv;
               out_divzero <= raise_dz;
            end
         end
      end
   end else begin : g_comb_out
      assign out_valid   = in_valid;
      assign out_result  = word;
      assign out_invalid = raise_inv;
      assign out_divzero = raise_dz;
   end
endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk #(
   parameter int FRAC_W = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_mode,
   input logic [31:0] in_operand,
   input logic        out_valid,
   input logic [31:0] out_result,
   input logic        out_invalid,
   input logic        out_divzero
);
   logic fp_in, ui_in, exp_ones, exp_none, mant_any;
   assign fp_in    = in_valid && !in_mode;
   assign ui_in    = in_valid && in_mode;
   assign exp_ones = &in_operand[30:23];
   assign exp_none = ~|in_operand[30:23];
   assign mant_any = |in_operand[22:0];

   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_exp_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_in && !in_operand[31] && !exp_none && !exp_ones) |=>
      (!out_result[31] && out_result[30:23] ==
       8'((9'd380 - {1'b0, $past(in_operand[30:23])}) >> 1) &&
       !out_invalid && !out_divzero));
   p_qnan_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_in && exp_ones && in_operand[22]) |=>
      (out_result == 32'h7FC0_0000 && !out_invalid));
   p_flags_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_divzero));
   p_zero_dz_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_in && exp_none) |=>
      (out_divzero && out_result == {$past(in_operand[31]), 31'h7F80_0000}));
   p_neg_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_in && in_operand[31] && !exp_none && !(exp_ones && mant_any)) |=>
      (out_invalid && out_result == 32'h7FC0_0000));
   p_pos_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_in && in_operand == 32'h7F80_0000) |=>
      (out_result == 32'h0 && !out_invalid && !out_divzero));
   p_uint_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ui_in && in_operand[31:30] == 2'b00) |=> (out_result == 32'hFFFF_FFFF));
   p_uint_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ui_in && in_operand[31:30] != 2'b00) |=>
      (out_result[31] && out_result[30-FRAC_W:0] == '0));
   p_uint_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ui_in |=> (!out_invalid && !out_divzero));
endmodule

bind rsqrt_est rsqrt_est_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_mode     (in_mode),
   .in_operand  (in_operand),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_invalid (out_invalid),
   .out_divzero (out_divzero)
);

// File: tb/rsqrt_est_tb_top.sv
`timescale 1ns/1ps
module rsqrt_est_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_mode = 1'b0;
   logic [31:0] in_operand = '0;
   logic        out_valid, out_invalid, out_divzero;
   logic [31:0] out_result;
   int          n_checks = 0;
   int          n_bad = 0;
   bit          ended = 1'b0;

   always #4 clk = ~clk;

   rsqrt_est dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_mode (in_mode),
      .in_operand (in_operand), .out_valid (out_valid), .out_result (out_result),
      .out_invalid (out_invalid), .out_divzero (out_divzero)
   );

   typedef struct packed {
      logic        mode;
      logic [31:0] op;
      logic [31:0] res;
      logic        inv;
      logic        dz;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h7FC0_0000, 32'h7FC0_0000, 1'b0, 1'b0, 8'd3}, // R3 quiet NaN
      '{1'b0, 32'h7F80_0001, 32'h7FC0_0000, 1'b1, 1'b0, 8'd3}, // R3 signalling NaN
      '{1'b0, 32'hFFA0_0000, 32'h7FC0_0000, 1'b1, 1'b0, 8'd3}, // R3 negative signalling NaN
      '{1'b0, 32'h0000_0000, 32'h7F80_0000, 1'b0, 1'b1, 8'd4}, // R4 +0
      '{1'b0, 32'h8000_0000, 32'hFF80_0000, 1'b0, 1'b1, 8'd4}, // R4 -0
      '{1'b0, 32'h0040_0000, 32'h7F80_0000, 1'b0, 1'b1, 8'd4}, // R4 denormal
      '{1'b0, 32'h807F_FFFF, 32'hFF80_0000, 1'b0, 1'b1, 8'd4}, // R4 negative denormal
      '{1'b0, 32'hBF80_0000, 32'h7FC0_0000, 1'b1, 1'b0, 8'd5}, // R5 -1.0
      '{1'b0, 32'hFF80_0000, 32'h7FC0_0000, 1'b1, 1'b0, 8'd5}, // R5 -inf
      '{1'b0, 32'h7F80_0000, 32'h0000_0000, 1'b0, 1'b0, 8'd6}, // R6 +inf
      '{1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd7}, // R7 zero
      '{1'b1, 32'h3FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd7}, // R7 just below 0.25
      '{1'b0, 32'h4000_0000, 32'h3F34_8000, 1'b0, 1'b0, 8'd2}, // R2 2.0, even exponent
      '{1'b0, 32'h3F80_0000, 32'h3F7F_8000, 1'b0, 1'b0, 8'd2}, // R2 1.0, odd exponent
      '{1'b0, 32'h0080_0000, 32'h5EFF_8000, 1'b0, 1'b0, 8'd2}, // R2 smallest normal
      '{1'b1, 32'h8000_0000, 32'hB480_0000, 1'b0, 1'b0, 8'd8}, // R8 0.5
      '{1'b1, 32'h4000_0000, 32'hFF80_0000, 1'b0, 1'b0, 8'd9}  // R9 0.25
   };

   function automatic logic [7:0] ref_frac(input bit upper, input int q);
      real x;
      real y;
      int  s;
      x = upper ? (real'(q) + 0.5) / 256.0 : (real'(q) + 0.5) / 512.0;
      y = $floor(256.0 / $sqrt(x) + 0.5);
      s = int'(y);
      return 8'(s - 256);
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   endtask

   task automatic check(input string tag, input logic [31:0] ar, input logic [31:0] er,
                        input logic ai, input logic ei, input logic ad, input logic ed);
      n_checks++;
      if (ar !== er || ai !== ei || ad !== ed) begin
         n_bad++;
         $display("FAIL %s: got result=%h inv=%b dz=%b, expected result=%h inv=%b dz=%b",
                  tag, ar, ai, ad, er, ei, ed);
      end
   endtask

   // Present one operand, then read the registered answer at the next falling edge
   task automatic apply(input logic m, input logic [31:0] op, input string tag,
                        input logic [31:0] er, input logic ei, input logic ed);
      @(negedge clk);
      in_valid   = 1'b1;
      in_mode    = m;
      in_operand = op;
      @(negedge clk);
      in_valid = 1'b0;
      n_checks++;
      if (out_valid !== 1'b1) begin
         n_bad++;
         $display("FAIL R1 out_valid after %s: got %b expected 1", tag, out_valid);
      end
      check(tag, out_result, er, out_invalid, ei, out_divzero, ed);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_bad++;
      $display("FAIL R1 watchdog: got hung run, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", out_result, 32'h0, out_invalid, 1'b0, out_divzero, 1'b0);
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset out_valid: got %b expected 0", out_valid);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 idle out_valid: got %b expected 0", out_valid);
      end

      foreach (VECS[i]) begin
         apply(VECS[i].mode, VECS[i].op, $sformatf("R%0d vector %0d", VECS[i].req, i),
               VECS[i].res, VECS[i].inv, VECS[i].dz);
      end

      for (int t = 0; t < 128; t++) begin
         int          e_even;
         int          e_odd;
         logic [31:0] op;
         logic [31:0] er;
         e_even = 2 + 2 * (t % 126);
         e_odd  = 1 + 2 * (t % 127);
         // R2 even exponent, upper interval, junk below the index
         op = {1'b0, 8'(e_even), 7'(t), 16'(t * 517)};
         er = {1'b0, 8'((380 - e_even) / 2), ref_frac(1'b1, 128 + t), 15'h0};
         apply(1'b0, op, $sformatf("R2 even step %0d", t), er, 1'b0, 1'b0);
         // R2 odd exponent, lower interval
         op = {1'b0, 8'(e_odd), 7'(t), 16'(t * 2971)};
         er = {1'b0, 8'((380 - e_odd) / 2), ref_frac(1'b0, 128 + t), 15'h0};
         apply(1'b0, op, $sformatf("R2 odd step %0d", t), er, 1'b0, 1'b0);
         // R8 and R10: top bit set, upper interval
         op = {1'b1, 7'(t), 24'(t * 7919)};
         er = {1'b1, ref_frac(1'b1, 128 + t), 23'h0};
         apply(1'b1, op, $sformatf("R8 R10 step %0d", t), er, 1'b0, 1'b0);
         // R9 and R10: bits 31:30 = 01, lower interval
         op = {2'b01, 7'(t), 23'(t * 3331)};
         er = {1'b1, ref_frac(1'b0, 128 + t), 23'h0};
         apply(1'b1, op, $sformatf("R9 R10 step %0d", t), er, 1'b0, 1'b0);
      end

      // R2 largest finite exponent
      apply(1'b0, 32'h7F00_0000, "R2 largest exponent", 32'h1FB4_8000, 1'b0, 1'b0);
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 drop of out_valid: got %b expected 0", out_valid);
      end
      finish_run();
   end
endmodule